// File: doc/BRIEF.md
# Programmable Program-Memory Fetch Decoder

This block sits on the instruction-fetch path and routes each fetch to one of two places: the on-chip program memory or the external bus. On-chip program memory starts at address zero and runs up to a maximum address. Software sets that maximum at run time by writing a 3-bit size code.

The code can shrink the on-chip window to 1k, 2k, 4k, 8k or 16k bytes. It can also remove the on-chip window completely, so that the whole 64kB space is fetched externally. A region can be taken out of the map and put back later. Codes that have no defined size are rejected.

For every fetch presented on a cycle, the block registers one routing decision. On the next cycle it drives either the internal-select strobe, together with the on-chip address, or the external-fetch request.

Top module: `fetch_map_decoder`

## Requirements
- R1: After reset the size code is 5 (binary 101), so addresses 0000h to 3FFFh go on-chip and 4000h to FFFFh go external.
- R2: With size code k from 1 to 5, a fetch address below 1024·2^(k−1) goes on-chip and any higher address goes external. The highest on-chip addresses are 03FFh, 07FFh, 0FFFh, 1FFFh and 3FFFh.
- R3: With size code 0, every fetch address, 0000h included, goes external.
- R4: A write of code 6 or 7 is ignored, and the previously held code keeps governing routing.
- R5: A code write sampled on a clock edge governs fetches sampled on later edges. A fetch sampled on the same edge as the write uses the old code.
- R6: A fetch sampled on a clock edge produces exactly one of int_sel_o and ext_req_o for the following cycle. When no fetch was sampled, both outputs are low, including after reset.
- R7: mem_addr_o carries fetch address bits [13:0] during an internal fetch and is zero otherwise.
- R8: After the on-chip window has been removed with code 0, writing code 5 restores on-chip routing for low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_valid_i | input | 1 | A fetch is presented this cycle |
| fetch_addr_i | input | 16 | Fetch byte address |
| cfg_we_i | input | 1 | Size-code write strobe |
| cfg_wdata_i | input | 3 | Size code to write |
| int_sel_o | output | 1 | Fetch served by on-chip memory |
| ext_req_o | output | 1 | Fetch issued on the external bus |
| mem_addr_o | output | 14 | On-chip memory address |

## Verification
The bench probes each window one address below its limit and exactly at its limit. A comparison that is off by one, or that uses the wrong shift, would misroute one of those two fetches. It writes a code on the same edge as a fetch, which catches a design that applies the new code one cycle early. It writes both reserved codes and then fetches inside the held window; a design that accepts those codes would either map garbage or drop memory. Code 0 is checked at address 0000h, where a design that treats 0 as a 1k window would wrongly select on-chip memory.

// File: rtl/fetch_map_pkg.sv
package fetch_map_pkg;
  typedef struct packed {
    logic int_sel;
    logic ext_req;
  } route_t;

  localparam route_t ROUTE_IDLE = '{int_sel: 1'b0, ext_req: 1'b0};
endpackage

// File: rtl/fetch_map_cfg.sv
module fetch_map_cfg #(
  parameter int CODE_W     = 3,
  parameter int MAX_CODE   = 5,
  parameter int RESET_CODE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  logic              legal;

  assign legal = (int'(wdata_i) <= MAX_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              code_q <= CODE_W'(RESET_CODE);
    else if (we_i && legal)   code_q <= wdata_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/fetch_map_window.sv
module fetch_map_window #(
  parameter int ADDR_W    = 16,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 5,
  parameter int UNIT_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              on_chip_o
);
  localparam int NCODES = 1 << CODE_W;

  logic [NCODES-1:0] hit;

  // code k>0 maps [0, 2^(UNIT_LOG2+k-1)); code 0 and reserved map nothing
  for (genvar k = 0; k < NCODES; k++) begin : g_code
    if (k == 0 || k > MAX_CODE) begin : g_none
      assign hit[k] = 1'b0;
    end else begin : g_win
      localparam int LSB = UNIT_LOG2 + k - 1;
      assign hit[k] = (addr_i[ADDR_W-1:LSB] == '0);
    end
  end

  assign on_chip_o = hit[code_i];
endmodule

// File: rtl/fetch_map_route.sv
module fetch_map_route
  import fetch_map_pkg::*;
#(
  parameter int MEM_AW = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              on_chip_i,
  input  logic [MEM_AW-1:0] addr_i,
  output route_t            route_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  route_t            route_q;
  logic [MEM_AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= ROUTE_IDLE;
      addr_q  <= '0;
    end else begin
      route_q.int_sel <= valid_i && on_chip_i;
      route_q.ext_req <= valid_i && !on_chip_i;
      addr_q          <= (valid_i && on_chip_i) ? addr_i : '0;
    end
  end

  assign route_o    = route_q;
  assign mem_addr_o = addr_q;
endmodule

// File: rtl/fetch_map_decoder.sv
module fetch_map_decoder
  import fetch_map_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CODE_W     = 3,
  parameter int MAX_CODE   = 5,
  parameter int RESET_CODE = 5,
  parameter int UNIT_LOG2  = 10,
  localparam int MEM_AW    = UNIT_LOG2 + MAX_CODE - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              cfg_we_i,
  input  logic [CODE_W-1:0] cfg_wdata_i,
  output logic              int_sel_o,
  output logic              ext_req_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  logic [CODE_W-1:0] code_q;
  logic              on_chip;
  route_t            route;

  fetch_map_cfg #(
    .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .RESET_CODE(RESET_CODE)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .code_o(code_q)
  );

  fetch_map_window #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .UNIT_LOG2(UNIT_LOG2)
  ) u_window (
    .addr_i(fetch_addr_i), .code_i(code_q), .on_chip_o(on_chip)
  );

  fetch_map_route #(.MEM_AW(MEM_AW)) u_route (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(fetch_valid_i), .on_chip_i(on_chip),
    .addr_i(fetch_addr_i[MEM_AW-1:0]),
    .route_o(route), .mem_addr_o(mem_addr_o)
  );

  assign int_sel_o = route.int_sel;
  assign ext_req_o = route.ext_req;
endmodule

// File: rtl/fetch_map_decoder_chk.sv
module fetch_map_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5,
  parameter int MEM_AW   = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              cfg_we_i,
  input logic [CODE_W-1:0] cfg_wdata_i,
  input logic [CODE_W-1:0] code_q,
  input logic              int_sel_o,
  input logic              ext_req_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({int_sel_o, ext_req_o}));

  p_fetch_served_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> (int_sel_o || ext_req_o));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !(int_sel_o || ext_req_o));

  p_reserved_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && int'(cfg_wdata_i) > MAX_CODE) |=> $stable(code_q));

  p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(code_q) <= MAX_CODE);

  p_none_mapped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && code_q == '0) |=> ext_req_o);

  p_above_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_addr_i[ADDR_W-1:MEM_AW] != '0) |=> ext_req_o);

  p_addr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_sel_o |-> (mem_addr_o == '0));
endmodule

bind fetch_map_decoder fetch_map_decoder_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .MEM_AW(MEM_AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
  .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .code_q(code_q),
  .int_sel_o(int_sel_o), .ext_req_o(ext_req_o), .mem_addr_o(mem_addr_o)
);

// File: tb/fetch_map_decoder_tb.sv
module fetch_map_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_wdata_i = '0;
  logic        int_sel_o, ext_req_o;
  logic [13:0] mem_addr_o;

  int checks = 0;
  int fails  = 0;
  int model_code = 5;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fetch_map_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .int_sel_o(int_sel_o), .ext_req_o(ext_req_o), .mem_addr_o(mem_addr_o)
  );

  function automatic bit in_window(int addr, int code);
    if (code == 0) return 0;
    return addr < (1024 << (code - 1));
  endfunction

  task automatic compare(string tag, bit ei, bit ee, int ea);
    checks++;
    if (int_sel_o !== ei || ext_req_o !== ee || int'(mem_addr_o) !== ea) begin
      fails++;
      $display("FAIL %s: int=%0b ext=%0b addr=%h expected int=%0b ext=%0b addr=%h",
               tag, int_sel_o, ext_req_o, mem_addr_o, ei, ee, ea[13:0]);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare 2ns after
  task automatic step(string tag, bit v, int addr, bit we, int wd);
    bit ei, ee;
    int ea;
    @(negedge clk_i);
    fetch_valid_i = v; fetch_addr_i = 16'(addr);
    cfg_we_i = we;     cfg_wdata_i = 3'(wd);
    @(posedge clk_i);
    ei = v && in_window(addr, model_code);
    ee = v && !in_window(addr, model_code);
    ea = ei ? (addr & 16'h3FFF) : 0;
    if (we && wd <= 5) model_code = wd;
    #2;
    compare(tag, ei, ee, ea);
  endtask

  task automatic fetch(string tag, int addr);
    step(tag, 1'b1, addr, 1'b0, 0);
  endtask

  task automatic wr(string tag, int code);
    step(tag, 1'b0, 0, 1'b1, code);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6: both outputs low during reset
    compare("R6", 0, 0, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    compare("R6", 0, 0, 0);

    // R1: default 16k window
    fetch("R1", 16'h0000);
    fetch("R1", 16'h3FFF);
    fetch("R1", 16'h4000);
    fetch("R1", 16'hFFFF);

    // R2: each window edge
    for (int k = 1; k <= 5; k++) begin
      int lim;
      lim = 1024 << (k - 1);
      wr("R2", k);
      fetch("R2", lim - 1);
      fetch("R2", lim);
      fetch("R7", (lim - 1) & 16'h2AAA);
    end

    // R3: nothing on-chip
    wr("R3", 0);
    fetch("R3", 16'h0000);
    fetch("R3", 16'h03FF);
    fetch("R3", 16'hFFFF);

    // R4: reserved codes ignored
    wr("R4", 5);
    wr("R4", 6);
    fetch("R4", 16'h3FFF);
    wr("R4", 7);
    fetch("R4", 16'h2000);
    wr("R4", 2);
    wr("R4", 7);
    fetch("R4", 16'h07FF);
    fetch("R4", 16'h0800);

    // R5: same-edge write does not affect that fetch
    wr("R5", 5);
    step("R5", 1'b1, 16'h0800, 1'b1, 1);
    fetch("R5", 16'h0800);
    fetch("R5", 16'h03FF);

    // R8: remove then restore
    wr("R8", 0);
    fetch("R8", 16'h0100);
    wr("R8", 5);
    fetch("R8", 16'h0100);

    // R6: idle cycles
    repeat (3) step("R6", 1'b0, 16'h0123, 1'b0, 0);

    // R7: mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      bit v, we;
      int a, c;
      v  = ($urandom_range(0, 3) != 0);
      we = ($urandom_range(0, 7) == 0);
      c  = $urandom_range(0, 7);
      a  = $urandom_range(0, 1) ? $urandom_range(0, 16'h4FFF) : $urandom_range(0, 16'hFFFF);
      step("R7", v, a, we, c);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule